// File: doc/BRIEF.md
# Latched 4-to-16 One-Hot Decoder

The block turns a binary select code into a single active line out of sixteen. The code passes through a hold stage governed by a strobe: while the strobe is high the stage is transparent and the outputs track the code inputs directly. When the strobe drops, the stage keeps the last code it saw and ignores later changes on the code inputs. An inhibit input forces every output to its inactive level without disturbing the held code. The held code shows again as soon as inhibit is released.

A parameter fixes the output polarity. In the active-high build the selected line is 1 and the rest are 0. In the active-low build the selected line is 0 and the rest are 1. A second parameter picks how the hold stage is built. The default samples the code on each rising clock edge while the strobe is high, with a combinational bypass that keeps the strobe-high path transparent. This suits fully synchronous designs. The alternative is a true level-sensitive latch.

Top module: `latched_dec`

## Requirements
- R1: While strobe_i is 1 and inhibit_i is 0, the active output is the line whose index equals data_i, in the same cycle that data_i changes.
- R2: While strobe_i is 0, the outputs keep the code sampled at the last rising clock edge at which strobe_i was 1. Changes on data_i have no effect on out_o.
- R3: data_i is an unsigned binary index with bit 3 as the most significant bit. Code n selects out_o[n], so 4'b0000 selects out_o[0] and 4'b1111 selects out_o[15].
- R4: With ACTIVE_HIGH=1, exactly one bit of out_o is 1 and all others are 0 whenever inhibit_i is 0.
- R5: With ACTIVE_HIGH=0, exactly one bit of out_o is 0 and all others are 1 whenever inhibit_i is 0.
- R6: While inhibit_i is 1, every bit of out_o sits at its inactive level: 16'h0000 for ACTIVE_HIGH=1 and 16'hFFFF for ACTIVE_HIGH=0. This holds in both the transparent phase and the hold phase.
- R7: inhibit_i does not alter the held code. A code captured before or during inhibit is shown once inhibit_i returns to 0.
- R8: While rst_ni is 0, and after reset until the strobe first rises, the held code is 0, so out_o selects line 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock for the clocked hold stage |
| rst_ni | input | 1 | Asynchronous reset, active low; clears the held code |
| data_i | input | 4 | Binary select code |
| strobe_i | input | 1 | 1 = transparent, 0 = hold |
| inhibit_i | input | 1 | 1 = all outputs at the inactive level |
| out_o | output | 16 | Decoded lines at the polarity set by ACTIVE_HIGH |

## Verification
Strobe and inhibit can change in the same cycle. The riskiest case is the strobe falling while inhibit is high: the code present at the last sampled edge must still be captured, even though no output shows it. The bench raises inhibit, moves the code, drops the strobe and then scrambles data_i before it releases inhibit. The reference model expects the line of the last code sampled with the strobe high. It compares both polarity builds against this model on every clock.

// File: rtl/latched_dec_pkg.sv
package latched_dec_pkg;
  typedef enum logic {
    HOLD_CLOCKED = 1'b0,
    HOLD_LATCH   = 1'b1
  } hold_mode_e;
endpackage

// File: rtl/latched_dec_hold.sv
module latched_dec_hold
  import latched_dec_pkg::*;
#(
  parameter int         CODE_W    = 4,
  parameter hold_mode_e HOLD_MODE = HOLD_CLOCKED
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] data_i,
  input  logic              strobe_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] held_q;

  generate
    if (HOLD_MODE == HOLD_CLOCKED) begin : g_clocked
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       held_q <= '0;
        else if (strobe_i) held_q <= data_i;
      end
      // bypass keeps the strobe-high path transparent
      assign code_o = strobe_i ? data_i : held_q;

      assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!strobe_i && $past(!strobe_i)) |-> $stable(code_o));
    end else begin : g_latch
      logic unused_clk;
      assign unused_clk = clk_i;
      always_latch begin
        if (!rst_ni)       held_q = '0;
        else if (strobe_i) held_q = data_i;
      end
      assign code_o = held_q;
    end
  endgenerate
endmodule

// File: rtl/latched_dec_onehot.sv
module latched_dec_onehot #(
  parameter int CODE_W = 4,
  localparam int LINES = 1 << CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic [LINES-1:0]  onehot_o
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign onehot_o[i] = (code_i == CODE_W'(i));
  end

  assert_single_line_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(onehot_o) == 1);
endmodule

// File: rtl/latched_dec_drive.sv
module latched_dec_drive #(
  parameter int LINES       = 16,
  parameter bit ACTIVE_HIGH = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] onehot_i,
  input  logic             inhibit_i,
  output logic [LINES-1:0] out_o
);
  logic [LINES-1:0] active;

  assign active = inhibit_i ? '0 : onehot_i;

  generate
    if (ACTIVE_HIGH) begin : g_high
      assign out_o = active;
      assert_one_active_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !inhibit_i |-> $countones(out_o) == 1);
      assert_blank_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        inhibit_i |-> out_o == '0);
    end else begin : g_low
      assign out_o = ~active;
      assert_one_active_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !inhibit_i |-> $countones(~out_o) == 1);
      assert_blank_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        inhibit_i |-> out_o == '1);
    end
  endgenerate
endmodule

// File: rtl/latched_dec.sv
module latched_dec
  import latched_dec_pkg::*;
#(
  parameter int         CODE_W      = 4,
  parameter bit         ACTIVE_HIGH = 1'b1,
  parameter hold_mode_e HOLD_MODE   = HOLD_CLOCKED,
  localparam int        LINES       = 1 << CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] data_i,
  input  logic              strobe_i,
  input  logic              inhibit_i,
  output logic [LINES-1:0]  out_o
);
  logic [CODE_W-1:0] code;
  logic [LINES-1:0]  onehot;

  latched_dec_hold #(.CODE_W(CODE_W), .HOLD_MODE(HOLD_MODE)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i),
    .strobe_i(strobe_i), .code_o(code)
  );

  latched_dec_onehot #(.CODE_W(CODE_W)) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .code_i(code), .onehot_o(onehot)
  );

  latched_dec_drive #(.LINES(LINES), .ACTIVE_HIGH(ACTIVE_HIGH)) u_drive (
    .clk_i(clk_i), .rst_ni(rst_ni), .onehot_i(onehot),
    .inhibit_i(inhibit_i), .out_o(out_o)
  );

  logic [LINES-1:0] out_act;
  assign out_act = ACTIVE_HIGH ? out_o : ~out_o;

  assert_transparent_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !inhibit_i) |-> out_act == (LINES'(1) << data_i));
endmodule

// File: tb/latched_dec_test.sv
`timescale 1ns/1ps
module latched_dec_test;
  import latched_dec_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  data = 4'd0;
  logic        strobe = 1'b0;
  logic        inhibit = 1'b0;
  logic [15:0] out_hi, out_lo;
  string       tag = "R8";
  bit          checking = 1'b1;
  bit          done = 1'b0;
  int          n_checks = 0;
  int          n_fail = 0;
  int          ref_held = 0;

  always #4 clk = ~clk;

  latched_dec #(.CODE_W(4), .ACTIVE_HIGH(1'b1), .HOLD_MODE(HOLD_CLOCKED)) uut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data),
    .strobe_i(strobe), .inhibit_i(inhibit), .out_o(out_hi)
  );

  latched_dec #(.CODE_W(4), .ACTIVE_HIGH(1'b0), .HOLD_MODE(HOLD_CLOCKED)) uut_low (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data),
    .strobe_i(strobe), .inhibit_i(inhibit), .out_o(out_lo)
  );

  // behavioural reference: held code updates at edges seen with strobe high
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ref_held <= 0;
    else if (strobe) ref_held <= int'(data);
  end

  always @(negedge clk) begin
    if (checking) begin
      int          sel;
      logic [15:0] exp_hi;
      sel    = strobe ? int'(data) : ref_held;
      exp_hi = inhibit ? 16'h0000 : (16'h0001 << sel);
      n_checks++;
      if (out_hi !== exp_hi) begin
        n_fail++;
        $display("FAIL %s R4 active-high: got %h expected %h", tag, out_hi, exp_hi);
      end
      n_checks++;
      if (out_lo !== ~exp_hi) begin
        n_fail++;
        $display("FAIL %s R5 active-low: got %h expected %h", tag, out_lo, ~exp_hi);
      end
    end
  end

  task automatic step(input logic [3:0] d, input logic s, input logic i, input string t);
    @(posedge clk);
    #1;
    data = d; strobe = s; inhibit = i; tag = t;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    // R8: reset holds code 0 even when data moves
    tag = "R8";
    data = 4'd7;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step(4'd11, 1'b0, 1'b0, "R8");
    step(4'd5,  1'b0, 1'b0, "R8");

    // R3: every code in ascending order, transparent
    for (int c = 0; c < 16; c++) step(4'(c), 1'b1, 1'b0, "R3");

    // R1: code moving every cycle while transparent
    step(4'd3,  1'b1, 1'b0, "R1");
    step(4'd12, 1'b1, 1'b0, "R1");
    step(4'd6,  1'b1, 1'b0, "R1");

    // R2: capture 9, then scramble data with strobe low
    step(4'd9,  1'b1, 1'b0, "R2");
    step(4'd1,  1'b0, 1'b0, "R2");
    step(4'd15, 1'b0, 1'b0, "R2");
    step(4'd0,  1'b0, 1'b0, "R2");
    step(4'd4,  1'b0, 1'b0, "R2");

    // R6/R7: inhibit during the hold phase, then release
    step(4'd2,  1'b0, 1'b1, "R6");
    step(4'd8,  1'b0, 1'b1, "R6");
    step(4'd13, 1'b0, 1'b0, "R7");

    // R6: inhibit during the transparent phase
    step(4'd10, 1'b1, 1'b1, "R6");
    step(4'd14, 1'b1, 1'b1, "R6");
    // strobe falls while inhibited; 14 was sampled with strobe high
    step(4'd5,  1'b0, 1'b1, "R7");
    step(4'd3,  1'b0, 1'b1, "R7");
    step(4'd0,  1'b0, 1'b0, "R7");
    step(4'd7,  1'b0, 1'b0, "R7");

    // strobe and inhibit change in the same cycle
    step(4'd1,  1'b1, 1'b1, "R6");
    step(4'd15, 1'b0, 1'b0, "R2");
    step(4'd2,  1'b1, 1'b0, "R1");
    step(4'd2,  1'b0, 1'b1, "R7");
    step(4'd9,  1'b0, 1'b0, "R7");

    @(posedge clk);
    #1 checking = 1'b0;
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule